// File: doc/BRIEF.md
# Dual-Width Instruction Prefetch Queue

This block sits between instruction memory and the decode stage of a core that executes either 32-bit (wide) or 16-bit (narrow) instructions. It keeps two opcode slots. Decode is offered the older slot only once both slots are valid. On each accepted decode handshake the younger slot moves forward, and the freed slot is refilled from the program counter. The program counter advances by the instruction size of the current state on every accepted fetch.

A branch or a state switch reloads the queue. Both slots are emptied and the program counter is loaded with the aligned target. The next two fetches refill the queue from the target and from target plus one instruction. When the first new opcode reaches decode, `exec_pc` therefore reads two instructions ahead of it: target+8 in the wide state, target+4 in the narrow state. A reload cycle never also advances the program counter. If a branch and a state switch arrive in the same cycle, the state switch wins.

The fetch port is valid/ready. A request counts only in a cycle where both `fetch_valid` and `fetch_ready` are high, and the read data must be valid in that same cycle. While `fetch_ready` is low the request is held with the same address and nothing in the queue changes. The decode port is also valid/ready. While `dec_ready` is low the offered opcode is held and no fetch is requested.

Top module: `pfq_top`

## Requirements
- R1: After reset both slots are empty, `dec_valid` is 0, the state is wide (`fetch_half`=0), and `exec_pc` and `fetch_addr` equal RESET_PC (default 0).
- R2: `dec_valid` is high only while both slots hold an opcode. `dec_op` is always the older slot.
- R3: After a wide reload to target T, the queue fetches T, then T+4. The first opcode offered is the word at T, with `exec_pc` = T+8.
- R4: In the narrow state each fetch has `fetch_half`=1. The opcode is `fetch_rdata[15:0]` zero-extended to 32 bits. After a narrow reload to T the first opcode is the half at T, with `exec_pc` = T+4.
- R5: Every accepted fetch advances `exec_pc` by 4 (wide) or 2 (narrow). While `dec_valid` is high, `exec_pc` equals the opcode's address plus two instruction sizes. With both ports ready, one opcode is issued per cycle.
- R6: `br_valid` empties the queue and loads `br_pc` aligned for the current state: bit 0 cleared when narrow, bits 1:0 cleared when wide. In that cycle `dec_valid` and `fetch_valid` are 0 and the program counter does not advance.
- R7: `xs_valid` sets the state to `xs_narrow` (1 = narrow) and reloads at `xs_pc` aligned for the new state.
- R8: When `br_valid` and `xs_valid` are high in the same cycle, the state-switch target and state take effect. A reload in the cycle right after another reload replaces it.
- R9: While `fetch_valid` is high and `fetch_ready` is low, the next cycle keeps `fetch_valid` high with the same address, unless a reload occurs.
- R10: While `dec_valid` is high and `dec_ready` is low, `dec_op` stays stable and `fetch_valid` is 0.
- R11: Every fetch address is aligned to the access width (2 bytes when `fetch_half`=1, 4 bytes otherwise).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | Branch reload in the current state |
| br_pc | input | AW | Branch target |
| xs_valid | input | 1 | State-switch reload |
| xs_pc | input | AW | State-switch target |
| xs_narrow | input | 1 | New state: 1 = narrow, 0 = wide |
| fetch_valid | output | 1 | Fetch request valid |
| fetch_ready | input | 1 | Memory accepts the request; data valid this cycle |
| fetch_addr | output | AW | Fetch address |
| fetch_half | output | 1 | Access width: 1 = 16-bit, 0 = 32-bit |
| fetch_rdata | input | OP_W | Fetch response data |
| dec_valid | output | 1 | Opcode offered to decode |
| dec_ready | input | 1 | Decode accepts the opcode |
| dec_op | output | OP_W | Oldest opcode |
| dec_narrow | output | 1 | Current state (1 = narrow) |
| exec_pc | output | AW | Program counter, two instructions ahead of `dec_op` |

## Verification
A reload takes effect at the first clock edge after it is presented. One edge later the fetch address and `exec_pc` show the aligned target. The first opcode reaches decode two accepted fetches after that, which is three edges after the reload when memory is always ready. In streaming mode each further opcode follows one edge after the previous one. Inputs are driven just after the falling edge. Outputs are sampled a fraction of a nanosecond later, before the next rising edge, so each check sees the cycle whose registered state has just been counted. Waits for a filled queue poll once per cycle under a bound.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  typedef enum logic {
    ISA_WIDE   = 1'b0,
    ISA_NARROW = 1'b1
  } isa_e;
endpackage

// File: rtl/pfq_redirect.sv
// Merges the two reload sources and aligns the target to the state it selects.
module pfq_redirect
  import pfq_pkg::*;
#(
  parameter int AW   = 32,
  parameter int OP_W = 32
) (
  input  logic          br_valid,
  input  logic [AW-1:0] br_pc,
  input  logic          xs_valid,
  input  logic [AW-1:0] xs_pc,
  input  logic          xs_narrow,
  input  isa_e          cur_state,
  output logic          redir,
  output logic [AW-1:0] redir_pc,
  output isa_e          redir_state
);
  localparam int WSTEP = OP_W / 8;
  localparam int NSTEP = OP_W / 16;
  localparam logic [AW-1:0] WMASK = ~(AW'(WSTEP) - AW'(1));
  localparam logic [AW-1:0] NMASK = ~(AW'(NSTEP) - AW'(1));

  logic [AW-1:0] raw_pc;

  always_comb begin
    redir = br_valid | xs_valid;
    if (xs_valid) begin
      raw_pc      = xs_pc;
      redir_state = xs_narrow ? ISA_NARROW : ISA_WIDE;
    end else begin
      raw_pc      = br_pc;
      redir_state = cur_state;
    end
    redir_pc = raw_pc & ((redir_state == ISA_NARROW) ? NMASK : WMASK);
  end
endmodule

// File: rtl/pfq_pc_ctr.sv
// Program counter and instruction-state register.
module pfq_pc_ctr
  import pfq_pkg::*;
#(
  parameter int          AW       = 32,
  parameter int          OP_W     = 32,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          redir,
  input  logic [AW-1:0] redir_pc,
  input  isa_e          redir_state,
  input  logic          adv,
  output logic [AW-1:0] pc,
  output isa_e          state
);
  localparam logic [AW-1:0] WSTEP = AW'(OP_W / 8);
  localparam logic [AW-1:0] NSTEP = AW'(OP_W / 16);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc    <= RESET_PC;
      state <= ISA_WIDE;
    end else if (redir) begin
      pc    <= redir_pc;
      state <= redir_state;
    end else if (adv) begin
      pc    <= pc + ((state == ISA_NARROW) ? NSTEP : WSTEP);
    end
  end
endmodule

// File: rtl/pfq_slots.sv
// Two-entry opcode store; slot 0 is the older entry.
module pfq_slots #(
  parameter int OP_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            issue,
  input  logic            wr_en,
  input  logic [OP_W-1:0] wr_op,
  output logic            full,
  output logic [OP_W-1:0] head
);
  logic [1:0]           vld, vld_n;
  logic [1:0][OP_W-1:0] ops, ops_n;

  always_comb begin
    vld_n = vld;
    ops_n = ops;
    if (flush) begin
      vld_n = '0;
    end else if (issue) begin
      vld_n[0] = vld[1];
      ops_n[0] = ops[1];
      vld_n[1] = wr_en;
      if (wr_en) ops_n[1] = wr_op;
    end else if (wr_en) begin
      if (!vld[0]) begin
        vld_n[0] = 1'b1;
        ops_n[0] = wr_op;
      end else begin
        vld_n[1] = 1'b1;
        ops_n[1] = wr_op;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      ops <= '0;
    end else begin
      vld <= vld_n;
      ops <= ops_n;
    end
  end

  assign full = &vld;
  assign head = ops[0];
endmodule

// File: rtl/pfq_top.sv
module pfq_top
  import pfq_pkg::*;
#(
  parameter int            AW       = 32,
  parameter int            OP_W     = 32,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            br_valid,
  input  logic [AW-1:0]   br_pc,
  input  logic            xs_valid,
  input  logic [AW-1:0]   xs_pc,
  input  logic            xs_narrow,
  output logic            fetch_valid,
  input  logic            fetch_ready,
  output logic [AW-1:0]   fetch_addr,
  output logic            fetch_half,
  input  logic [OP_W-1:0] fetch_rdata,
  output logic            dec_valid,
  input  logic            dec_ready,
  output logic [OP_W-1:0] dec_op,
  output logic            dec_narrow,
  output logic [AW-1:0]   exec_pc
);
  localparam int HALF_W = OP_W / 2;

  logic          redir;
  logic [AW-1:0] redir_pc;
  isa_e          redir_state;
  isa_e          state;
  logic [AW-1:0] pc;
  logic          full;
  logic          issue;
  logic          fetch_acc;
  logic [OP_W-1:0] fill_op;

  pfq_redirect #(.AW(AW), .OP_W(OP_W)) u_redir (
    .br_valid    (br_valid),
    .br_pc       (br_pc),
    .xs_valid    (xs_valid),
    .xs_pc       (xs_pc),
    .xs_narrow   (xs_narrow),
    .cur_state   (state),
    .redir       (redir),
    .redir_pc    (redir_pc),
    .redir_state (redir_state)
  );

  pfq_pc_ctr #(.AW(AW), .OP_W(OP_W), .RESET_PC(RESET_PC)) u_pc (
    .clk         (clk),
    .rst_n       (rst_n),
    .redir       (redir),
    .redir_pc    (redir_pc),
    .redir_state (redir_state),
    .adv         (fetch_acc),
    .pc          (pc),
    .state       (state)
  );

  pfq_slots #(.OP_W(OP_W)) u_slots (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (redir),
    .issue (issue),
    .wr_en (fetch_acc),
    .wr_op (fill_op),
    .full  (full),
    .head  (dec_op)
  );

  // A reload outranks both handshakes in its cycle.
  assign dec_valid   = full & ~redir;
  assign issue       = dec_valid & dec_ready;
  assign fetch_valid = ~redir & (~full | dec_ready);
  assign fetch_acc   = fetch_valid & fetch_ready;
  assign fetch_addr  = pc;
  assign fetch_half  = (state == ISA_NARROW);
  assign dec_narrow  = fetch_half;
  assign exec_pc     = pc;
  assign fill_op     = fetch_half ? {{(OP_W-HALF_W){1'b0}}, fetch_rdata[HALF_W-1:0]}
                                  : fetch_rdata;
endmodule

// File: rtl/pfq_checker.sv
module pfq_checker #(
  parameter int AW   = 32,
  parameter int OP_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            br_valid,
  input logic [AW-1:0]   br_pc,
  input logic            xs_valid,
  input logic [AW-1:0]   xs_pc,
  input logic            xs_narrow,
  input logic            fetch_valid,
  input logic            fetch_ready,
  input logic [AW-1:0]   fetch_addr,
  input logic            fetch_half,
  input logic            dec_valid,
  input logic            dec_ready,
  input logic [OP_W-1:0] dec_op,
  input logic [AW-1:0]   exec_pc
);
  localparam logic [AW-1:0] WSTEP = AW'(OP_W / 8);
  localparam logic [AW-1:0] NSTEP = AW'(OP_W / 16);
  localparam logic [AW-1:0] WMASK = ~(WSTEP - AW'(1));
  localparam logic [AW-1:0] NMASK = ~(NSTEP - AW'(1));

  logic       any_redir;
  logic [1:0] fills;
  assign any_redir = br_valid | xs_valid;

  // Accepted fetches since the last reload, saturating at two.
  always_ff @(posedge clk) begin
    if (!rst_n || any_redir) fills <= '0;
    else if (fetch_valid && fetch_ready && fills != 2'd2) fills <= fills + 2'd1;
  end

  p_two_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> fills == 2'd2);

  p_pc_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_ready && !any_redir) |=>
      exec_pc == $past(fetch_addr) + ($past(fetch_half) ? NSTEP : WSTEP));

  p_redir_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    any_redir |-> (!dec_valid && !fetch_valid));

  p_switch_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xs_valid |=> (fetch_half == $past(xs_narrow)) &&
                 (exec_pc == ($past(xs_pc) & ($past(xs_narrow) ? NMASK : WMASK))));

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_ready && !any_redir) |=>
      (any_redir || (fetch_valid && fetch_addr == $past(fetch_addr))));

  p_dec_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ready) |-> !fetch_valid);

  p_dec_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ready) |=> $stable(dec_op));

  p_addr_align_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> ((fetch_addr & (fetch_half ? ~NMASK : ~WMASK)) == '0));
endmodule

bind pfq_top pfq_checker #(.AW(AW), .OP_W(OP_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .br_valid    (br_valid),
  .br_pc       (br_pc),
  .xs_valid    (xs_valid),
  .xs_pc       (xs_pc),
  .xs_narrow   (xs_narrow),
  .fetch_valid (fetch_valid),
  .fetch_ready (fetch_ready),
  .fetch_addr  (fetch_addr),
  .fetch_half  (fetch_half),
  .dec_valid   (dec_valid),
  .dec_ready   (dec_ready),
  .dec_op      (dec_op),
  .exec_pc     (exec_pc)
);

// File: tb/sim_pfq_top.sv
`timescale 1ns/100ps
module sim_pfq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        br_valid = 1'b0;
  logic [31:0] br_pc = '0;
  logic        xs_valid = 1'b0;
  logic [31:0] xs_pc = '0;
  logic        xs_narrow = 1'b0;
  logic        fetch_valid, fetch_half, dec_valid, dec_narrow;
  logic        fetch_ready = 1'b1;
  logic        dec_ready = 1'b0;
  logic [31:0] fetch_addr, fetch_rdata, dec_op, exec_pc;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  // Memory model: wide word and narrow half are both derived from the address.
  assign fetch_rdata = fetch_half ? {16'hDEAD, fetch_addr[15:0]}
                                  : {~fetch_addr[15:0], fetch_addr[15:0]};

  pfq_top u0 (
    .clk(clk), .rst_n(rst_n),
    .br_valid(br_valid), .br_pc(br_pc),
    .xs_valid(xs_valid), .xs_pc(xs_pc), .xs_narrow(xs_narrow),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .fetch_addr(fetch_addr), .fetch_half(fetch_half), .fetch_rdata(fetch_rdata),
    .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_op(dec_op),
    .dec_narrow(dec_narrow), .exec_pc(exec_pc)
  );

  function automatic logic [31:0] wop(input logic [31:0] a);
    return {~a[15:0], a[15:0]};
  endfunction
  function automatic logic [31:0] nop(input logic [31:0] a);
    return {16'h0000, a[15:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Advance to the sampling point of the next cycle.
  task automatic cyc();
    @(negedge clk);
    #0.5;
  endtask

  task automatic wait_full(input string req);
    for (int i = 0; i < 20; i++) begin
      if (dec_valid) return;
      cyc();
    end
    chk(req, {31'd0, dec_valid}, 32'd1);
  endtask

  task automatic reload(input bit use_br, input logic [31:0] bpc,
                        input bit use_xs, input logic [31:0] xpc, input bit xn);
    @(negedge clk);
    br_valid = use_br; br_pc = bpc;
    xs_valid = use_xs; xs_pc = xpc; xs_narrow = xn;
    #0.5;
    chk("R6 dec_valid during reload", {31'd0, dec_valid}, 32'd0);
    chk("R6 fetch_valid during reload", {31'd0, fetch_valid}, 32'd0);
    @(negedge clk);
    br_valid = 1'b0; xs_valid = 1'b0;
    #0.5;
  endtask

  task automatic t_reset();
    chk("R1 dec_valid", {31'd0, dec_valid}, 32'd0);
    chk("R1 exec_pc", exec_pc, 32'h0);
    chk("R1 fetch_addr", fetch_addr, 32'h0);
    chk("R1 fetch_half", {31'd0, fetch_half}, 32'd0);
  endtask

  task automatic t_wide_fill();
    chk("R2 empty after fetch 0", {31'd0, dec_valid}, 32'd0);
    cyc();
    chk("R3 second fetch addr", fetch_addr, 32'h4);
    chk("R2 one slot only", {31'd0, dec_valid}, 32'd0);
    cyc();
    chk("R2 full", {31'd0, dec_valid}, 32'd1);
    chk("R3 first op", dec_op, wop(32'h0));
    chk("R3 exec_pc", exec_pc, 32'h8);
  endtask

  task automatic t_stream();
    logic [31:0] a = 32'h0;
    dec_ready = 1'b1;
    for (int k = 0; k < 4; k++) begin
      chk("R5 stream valid", {31'd0, dec_valid}, 32'd1);
      chk("R5 stream op", dec_op, wop(a));
      chk("R5 stream pc", exec_pc, a + 32'h8);
      cyc();
      a = a + 32'h4;
    end
    dec_ready = 1'b0;
  endtask

  task automatic t_backpressure();
    logic [31:0] op0, pc0;
    cyc();
    op0 = dec_op; pc0 = exec_pc;
    for (int k = 0; k < 3; k++) begin
      cyc();
      chk("R10 op held", dec_op, op0);
      chk("R10 no fetch", {31'd0, fetch_valid}, 32'd0);
      chk("R10 pc held", exec_pc, pc0);
    end
  endtask

  task automatic t_mem_stall();
    fetch_ready = 1'b0;
    reload(1'b1, 32'h102, 1'b0, 32'h0, 1'b0);
    chk("R6 wide branch align", fetch_addr, 32'h100);
    for (int k = 0; k < 4; k++) begin
      cyc();
      chk("R9 request held", {31'd0, fetch_valid}, 32'd1);
      chk("R9 addr held", fetch_addr, 32'h100);
      chk("R9 pc held", exec_pc, 32'h100);
    end
    fetch_ready = 1'b1;
    wait_full("R9 refill after stall");
    chk("R9 op after stall", dec_op, wop(32'h100));
    chk("R3 pc after stall", exec_pc, 32'h108);
  endtask

  task automatic t_branch_in_stream();
    dec_ready = 1'b1;
    cyc();
    reload(1'b1, 32'h203, 1'b0, 32'h0, 1'b0);
    chk("R6 pc at target", exec_pc, 32'h200);
    chk("R6 queue emptied", {31'd0, dec_valid}, 32'd0);
    wait_full("R6 refill");
    chk("R6 op", dec_op, wop(32'h200));
    chk("R6 pc", exec_pc, 32'h208);
    dec_ready = 1'b0;
  endtask

  task automatic t_switch_narrow();
    reload(1'b0, 32'h0, 1'b1, 32'h1003, 1'b1);
    chk("R7 narrow align", fetch_addr, 32'h1002);
    chk("R7 narrow width", {31'd0, fetch_half}, 32'd1);
    cyc();
    chk("R4 second narrow fetch", fetch_addr, 32'h1004);
    wait_full("R4 refill");
    chk("R4 zero-extended op", dec_op, nop(32'h1002));
    chk("R4 pc", exec_pc, 32'h1006);
    chk("R4 dec_narrow", {31'd0, dec_narrow}, 32'd1);
    dec_ready = 1'b1;
    cyc();
    chk("R5 narrow next op", dec_op, nop(32'h1004));
    chk("R5 narrow pc", exec_pc, 32'h1008);
    dec_ready = 1'b0;
    reload(1'b1, 32'h301, 1'b0, 32'h0, 1'b0);
    chk("R6 narrow branch align", fetch_addr, 32'h300);
    chk("R6 state kept", {31'd0, fetch_half}, 32'd1);
  endtask

  task automatic t_both();
    reload(1'b1, 32'h500, 1'b1, 32'h607, 1'b0);
    chk("R8 switch wins addr", fetch_addr, 32'h604);
    chk("R8 switch wins width", {31'd0, fetch_half}, 32'd0);
    wait_full("R8 refill");
    chk("R8 op", dec_op, wop(32'h604));
    chk("R8 pc", exec_pc, 32'h60C);
    // Back-to-back reloads: the later one replaces the earlier.
    @(negedge clk);
    br_valid = 1'b1; br_pc = 32'h700;
    @(negedge clk);
    br_valid = 1'b0;
    xs_valid = 1'b1; xs_pc = 32'h801; xs_narrow = 1'b1;
    @(negedge clk);
    xs_valid = 1'b0;
    #0.5;
    chk("R8 second reload addr", fetch_addr, 32'h800);
    wait_full("R8 second refill");
    chk("R8 second reload op", dec_op, nop(32'h800));
    chk("R8 second reload pc", exec_pc, 32'h804);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #0.5;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    t_wide_fill();
    t_stream();
    t_backpressure();
    t_mem_stall();
    t_branch_in_stream();
    t_switch_narrow();
    t_both();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule